// File: doc/BRIEF.md
# Saturating Receive Statistics Counters

This block keeps the receive-side statistics of a network port. Each time the receive path finishes a good frame it raises a one-cycle frame-done strobe. With the strobe it gives two lengths: the payload length without the 4-byte frame check sequence, and the on-wire length with it. The block uses the on-wire length to choose one of six size classes. It also counts every frame twice, once in a total-frames counter and once in a good-frames counter. Two wide octet totals each grow by the payload length plus four. No counter ever wraps: each one stops at its all-ones value.

Software, or a collection engine, reads a counter through a combinational index port. An octet total is wider than the read port, so it is read as a low word and a high word. All counters clear together on reset.

Top module: `rxstat_top`

## Requirements
- R1: The on-wire length picks the size class. Class 0 is exactly 64, class 1 is 65..127, class 2 is 128..255, class 3 is 256..511, class 4 is 512..1023 and class 5 is above 1023. Only the selected class counter goes up, by one.
- R2: A frame whose on-wire length is below 64 leaves every size class counter unchanged.
- R3: Every frame-done strobe adds one to the total-frames counter and one to the good-frames counter.
- R4: Each frame-done strobe adds the payload length plus 4 to both octet totals. The octet totals are twice the packet-counter width.
- R5: A counter at its all-ones value stays there when asked to grow. An octet total whose sum would overflow is set to all ones.
- R6: Read index map: indices 0..5 are size classes 0..5, 6 is total frames, 7 is good frames, 8/9 are the total-octets low/high words, and 10/11 are the good-octets low/high words. Any other index reads zero. Data follows the index in the same cycle.
- R7: Strobes on consecutive cycles are each counted in full.
- R8: When the active-low reset is asserted, every counter clears to zero at once. Counting resumes two clock edges after reset is released.
- R9: When the strobe is low, the length inputs have no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe per good received frame |
| data_len | input | LEN_W | Payload length without the check sequence |
| wire_len | input | LEN_W | Length including the check sequence |
| rd_idx | input | IDX_W | Counter select |
| rd_data | output | CNT_W | Selected counter or word |

## Verification
The bench walks on-wire lengths that sit on both sides of every class edge: 63/64, 64/65, 127/128, 255/256, 511/512 and 1023/1024. A comparison that is off by one would put a frame in the neighbouring class, or would count a runt.

With narrow counters, the bench drives past saturation. Two failures are caught this way: a counter that wraps back to a small value, and an octet total that drops the carry of a large add. Three strobes in a row catch a design that drops the second strobe of a pair.

An idle stretch with random lengths on the inputs catches a design that counts without the strobe. A missing +4 on the octet totals shows up on the very first frame.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int NBKT   = 6;
  localparam int IX_TOT = 6;
  localparam int IX_GD  = 7;
  localparam int NPKT   = 8;
  localparam int IX_TOL = 8;
  localparam int IX_TOH = 9;
  localparam int IX_GOL = 10;
  localparam int IX_GOH = 11;
  localparam int FCS_BYTES = 4;
  localparam int MIN_FRAME = 64;

  // exclusive lower bound of class k (k >= 1)
  function automatic int bkt_lo(input int k);
    return (k == 1) ? MIN_FRAME : (MIN_FRAME << (k - 1)) - 1;
  endfunction

  // inclusive upper bound of class k (k in 1..NBKT-2)
  function automatic int bkt_hi(input int k);
    return (128 << (k - 1)) - 1;
  endfunction
endpackage

// File: rtl/rxstat_rst_sync.sv
module rxstat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/rxstat_bucket_sel.sv
module rxstat_bucket_sel
  import rxstat_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] wire_len,
  output logic [NBKT-1:0]  hit
);
  for (genvar k = 0; k < NBKT; k++) begin : g_bkt
    if (k == 0) begin : g_exact
      localparam logic [LEN_W-1:0] EQ = LEN_W'(MIN_FRAME);
      assign hit[k] = (wire_len == EQ);
    end else if (k == NBKT - 1) begin : g_top
      localparam logic [LEN_W-1:0] LO = LEN_W'(bkt_lo(k));
      assign hit[k] = (wire_len > LO);
    end else begin : g_mid
      localparam logic [LEN_W-1:0] LO = LEN_W'(bkt_lo(k));
      localparam logic [LEN_W-1:0] HI = LEN_W'(bkt_hi(k));
      assign hit[k] = (wire_len > LO) && (wire_len <= HI);
    end
  end
endmodule

// File: rtl/rxstat_sat_ctr.sv
module rxstat_sat_ctr #(
  parameter int W    = 32,
  parameter int IN_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [IN_W-1:0] inc,
  output logic [W-1:0]    cnt
);
  localparam int PAD = W - IN_W;

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + {{(PAD + 1){1'b0}}, inc};
    cnt_d = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rxstat_top.sv
module rxstat_top
  import rxstat_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_vld,
  input  logic [LEN_W-1:0] data_len,
  input  logic [LEN_W-1:0] wire_len,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_data
);
  localparam int OCT_W = 2 * CNT_W;
  localparam int INC_W = LEN_W + 1;

  logic             rst_n_int;
  logic [NBKT-1:0]  bkt_hit;
  logic [CNT_W-1:0] pkt_cnt [NPKT];
  logic [OCT_W-1:0] tot_oct, good_oct;
  logic [INC_W-1:0] oct_inc;

  rxstat_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  rxstat_bucket_sel #(.LEN_W(LEN_W)) u_sel (.wire_len(wire_len), .hit(bkt_hit));

  for (genvar k = 0; k < NPKT; k++) begin : g_pkt
    logic ctr_en;
    if (k < NBKT) begin : g_class
      assign ctr_en = frame_vld & bkt_hit[k];
    end else begin : g_all
      assign ctr_en = frame_vld;
    end
    rxstat_sat_ctr #(.W(CNT_W), .IN_W(1)) u_ctr (
      .clk(clk), .rst_n(rst_n_int), .en(ctr_en), .inc(1'b1), .cnt(pkt_cnt[k])
    );
  end

  assign oct_inc = {1'b0, data_len} + INC_W'(FCS_BYTES);

  rxstat_sat_ctr #(.W(OCT_W), .IN_W(INC_W)) u_tot_oct (
    .clk(clk), .rst_n(rst_n_int), .en(frame_vld), .inc(oct_inc), .cnt(tot_oct)
  );
  rxstat_sat_ctr #(.W(OCT_W), .IN_W(INC_W)) u_good_oct (
    .clk(clk), .rst_n(rst_n_int), .en(frame_vld), .inc(oct_inc), .cnt(good_oct)
  );

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NPKT; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = pkt_cnt[k];
    end
    if (rd_idx == IDX_W'(IX_TOL)) rd_data = tot_oct[CNT_W-1:0];
    if (rd_idx == IDX_W'(IX_TOH)) rd_data = tot_oct[OCT_W-1:CNT_W];
    if (rd_idx == IDX_W'(IX_GOL)) rd_data = good_oct[CNT_W-1:0];
    if (rd_idx == IDX_W'(IX_GOH)) rd_data = good_oct[OCT_W-1:CNT_W];
  end
endmodule

// File: rtl/rxstat_chk.sv
module rxstat_chk #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_vld,
  input logic [LEN_W-1:0]     data_len,
  input logic [LEN_W-1:0]     wire_len,
  input logic [5:0]           hit,
  input logic [CNT_W-1:0]     bkt0,
  input logic [CNT_W-1:0]     tot_pkt,
  input logic [CNT_W-1:0]     good_pkt,
  input logic [2*CNT_W-1:0]   tot_oct
);
  localparam int OCT_W = 2 * CNT_W;
  localparam logic [OCT_W-1:0] SAFE = {OCT_W{1'b1}} - OCT_W'(64'd1 << (LEN_W + 1));
  localparam logic [LEN_W-1:0] RUNT = LEN_W'(64);

  // R1: a frame lands in at most one class
  a_r1_one_class: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));

  // R2: runts leave class 0 alone
  a_r2_runt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld && (wire_len < RUNT) |=> $stable(bkt0));

  // R3: both frame counters track each other
  a_r3_tot_eq_good: assert property (@(posedge clk) disable iff (!rst_n) tot_pkt == good_pkt);

  // R3 and R7: one more per strobe below saturation
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld && (tot_pkt != {CNT_W{1'b1}}) |=> tot_pkt == $past(tot_pkt) + CNT_W'(1));

  // R4: octet growth includes the check sequence
  a_r4_octets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld && (tot_oct < SAFE) |=>
      tot_oct == $past(tot_oct) + OCT_W'($past(data_len)) + OCT_W'(4));

  // R5: no wrap
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tot_oct >= $past(tot_oct) && tot_pkt >= $past(tot_pkt));

  // R9: idle leaves totals unchanged
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> $stable(tot_oct) && $stable(tot_pkt));
endmodule

bind rxstat_top rxstat_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_int), .frame_vld(frame_vld), .data_len(data_len),
  .wire_len(wire_len), .hit(bkt_hit), .bkt0(pkt_cnt[0]), .tot_pkt(pkt_cnt[6]),
  .good_pkt(pkt_cnt[7]), .tot_oct(tot_oct)
);

// File: tb/sim_rxstat_top.sv
`timescale 1ns/1ps
module sim_rxstat_top;
  localparam int LW = 12;
  localparam int CW = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_vld = 1'b0;
  logic [LW-1:0] data_len = '0;
  logic [LW-1:0] wire_len = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [CW-1:0] rd_data;

  int errs = 0;
  int nchk = 0;

  logic [CW-1:0]   m_pkt [8];
  logic [2*CW-1:0] m_oct;

  rxstat_top #(.LEN_W(LW), .CNT_W(CW), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .data_len(data_len),
    .wire_len(wire_len), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  // data_len[35:24], wire_len[23:12], expected class[11:0] (6 = none)
  localparam logic [35:0] VEC [13] = '{
    {12'd60,   12'd64,   12'd0}, {12'd56,   12'd60,   12'd6},
    {12'd61,   12'd65,   12'd1}, {12'd123,  12'd127,  12'd1},
    {12'd124,  12'd128,  12'd2}, {12'd251,  12'd255,  12'd2},
    {12'd252,  12'd256,  12'd3}, {12'd507,  12'd511,  12'd3},
    {12'd508,  12'd512,  12'd4}, {12'd1019, 12'd1023, 12'd4},
    {12'd1020, 12'd1024, 12'd5}, {12'd1496, 12'd1500, 12'd5},
    {12'd59,   12'd63,   12'd6}
  };

  task automatic model_clear();
    for (int k = 0; k < 8; k++) m_pkt[k] = '0;
    m_oct = '0;
  endtask

  task automatic model_frame(input int dl, input int cls);
    logic [2*CW:0] s;
    if (cls < 6 && m_pkt[cls] != '1) m_pkt[cls] = m_pkt[cls] + 1'b1;
    for (int k = 6; k < 8; k++) if (m_pkt[k] != '1) m_pkt[k] = m_pkt[k] + 1'b1;
    s = {1'b0, m_oct} + (2*CW+1)'(dl + 4);
    m_oct = s[2*CW] ? '1 : s[2*CW-1:0];
  endtask

  task automatic check(input int idx, input logic [CW-1:0] exp, input string tag);
    @(negedge clk);
    rd_idx = IW'(idx);
    #1;
    nchk++;
    if (rd_data !== exp) begin
      errs++;
      $display("FAIL %s idx=%0d actual=%0h expected=%0h", tag, idx, rd_data, exp);
    end
  endtask

  // R6: full read map walk
  task automatic check_all(input string tag);
    for (int k = 0; k < 8; k++) check(k, m_pkt[k], tag);
    check(8,  m_oct[CW-1:0],    tag);
    check(9,  m_oct[2*CW-1:CW], tag);
    check(10, m_oct[CW-1:0],    tag);
    check(11, m_oct[2*CW-1:CW], tag);
  endtask

  task automatic frame(input int dl, input int wl);
    @(negedge clk);
    frame_vld = 1'b1;
    data_len  = LW'(dl);
    wire_len  = LW'(wl);
    @(negedge clk);
    frame_vld = 1'b0;
  endtask

  function automatic int cls_of(input int wl);
    if (wl == 64)  return 0;
    if (wl < 64)   return 6;
    if (wl < 128)  return 1;
    if (wl < 256)  return 2;
    if (wl < 512)  return 3;
    if (wl < 1024) return 4;
    return 5;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R8 reset state");

    // R1 R2 R3 R4: class edges from the table
    for (int v = 0; v < 13; v++) begin
      frame(int'(VEC[v][35:24]), int'(VEC[v][23:12]));
      model_frame(int'(VEC[v][35:24]), int'(VEC[v][11:0]));
      check_all((VEC[v][11:0] == 12'd6) ? "R2 runt" : "R1 class");
    end

    // R6: unmapped indices read zero
    for (int k = 12; k < 16; k++) check(k, '0, "R6 unmapped");

    // R7: three strobes back to back
    @(negedge clk);
    frame_vld = 1'b1; data_len = 12'd100; wire_len = 12'd104;
    @(negedge clk); data_len = 12'd300; wire_len = 12'd304;
    @(negedge clk); data_len = 12'd60;  wire_len = 12'd64;
    @(negedge clk); frame_vld = 1'b0;
    model_frame(100, 1); model_frame(300, 3); model_frame(60, 0);
    check_all("R7 back to back");

    // R9: lengths move while strobe low
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      data_len = LW'($urandom);
      wire_len = LW'($urandom);
    end
    check_all("R9 idle");

    // R5: packet counters saturate
    for (int k = 0; k < 260; k++) begin
      frame(60, 64);
      model_frame(60, cls_of(64));
    end
    check_all("R5 packet saturation");

    // R5: octet totals saturate
    for (int k = 0; k < 18; k++) begin
      frame(4000, 4004);
      model_frame(4000, cls_of(4004));
    end
    check_all("R5 octet saturation");

    // R8: asynchronous clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_clear();
    check(6, '0, "R8 clear");
    check(8, '0, "R8 clear");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    frame(200, 204);
    model_frame(200, 2);
    check_all("R8 after release");

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule